// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by walking a two-level translation structure held in memory. A requester offers a linear address together with an access kind (read or write) and a privilege flag (user or supervisor) over a ready/valid handshake. The walker fetches a directory entry and then a page-table entry through a single-outstanding memory port. It returns either the physical address or a page fault carrying an error code and a fixed vector. The faulting linear address is held in a fault-address register.

When the paging-enable input is low, the request is passed straight through: the physical address equals the linear address and memory is not touched. When paging is on, the walker checks presence, write permission and privilege at both levels. It rejects directory entries that ask for large pages. It sets the accessed flag in each entry it uses, and the dirty flag in the page-table entry on writes, by writing the entry back. It writes an entry back only when one of those flags was clear.

Top module: `pgw_walker`

## Requirements
- R1: With `paging_en` low when a request is accepted, the response appears in the next cycle with `rsp_phys` equal to the linear address, `rsp_fault` low, and no memory request for that walk.
- R2: With paging on, the directory entry is read at `{dir_base[31:12],12'h000} + 4*lin[31:22]`. The table entry is read at `{dir_entry[31:12],12'h000} + 4*lin[21:12]`. A successful result is `{table_entry[31:12], lin[11:0]}`.
- R3: An entry with bit 0 (present) clear, at either level, ends the walk with a fault whose error-code bit 0 is 0.
- R4: A user access (`req_user`=1) that meets an entry with bit 2 (user-allowed) clear, at either level, faults with error-code bit 0 set. A supervisor access is not limited by bit 2.
- R5: A user write that meets an entry with bit 1 (writable) clear, at either level, faults. A supervisor write to such an entry succeeds.
- R6: A present directory entry with bit 7 (large page) set faults with error-code bit 0 set.
- R7: On a fault, `rsp_vector` is 14 and `fault_addr` holds the request's linear address. The error code is {bit 2 = user, bit 1 = write, bit 0 = entry present}. `fault_addr` keeps its value across successful walks and is 0 after reset.
- R8: A used entry whose bit 5 (accessed) is clear is written back with bit 5 set, at the address it was read from. A used entry with bit 5 already set is not written. A faulting entry is never written.
- R9: On a write, a table entry whose bit 6 (dirty) is clear is written back with bits 6 and 5 set. Reads never set bit 6.
- R10: `req_ready` is high only while no walk or response is pending. `rsp_valid` and its payload hold until `rsp_ready` is high.
- R11: A memory request keeps `mem_addr`, `mem_we` and `mem_wdata` stable until the cycle in which `mem_ack` is seen. `mem_rdata` is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| paging_en | input | 1 | Translation enable, sampled on request acceptance |
| dir_base | input | 32 | Physical base of the directory (bits 31:12 used as frame) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Walker idle and accepting |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user-mode access |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result consumed |
| rsp_phys | output | 32 | Physical address (valid when no fault) |
| rsp_fault | output | 1 | Page fault |
| rsp_err | output | 3 | Fault error code |
| rsp_vector | output | 8 | 14 on fault, else 0 |
| fault_addr | output | 32 | Last faulting linear address |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | 1 = write-back of an entry |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Updated entry |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Entry read data |

## Verification
The properties assume that the memory side raises `mem_ack` only while `mem_req` is high, and that it answers each access exactly once. They also assume that the requester holds `req_valid` and its payload until `req_ready` accepts them. The bench's memory model acknowledges only pending requests, after a latency that changes from access to access, and it drops the acknowledge in the cycle after. The requester drives each request at a falling edge and holds it until acceptance. It issues a new request only after the previous response has been consumed, so the expected entry contents are computed against settled memory.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
   localparam int unsigned BIT_PRESENT = 0;
   localparam int unsigned BIT_WRITE   = 1;
   localparam int unsigned BIT_USER    = 2;
   localparam int unsigned BIT_ACCESS  = 5;
   localparam int unsigned BIT_DIRTY   = 6;
   localparam int unsigned BIT_BIGPAGE = 7;

   localparam int unsigned ERR_PROT  = 0;
   localparam int unsigned ERR_WRITE = 1;
   localparam int unsigned ERR_USER  = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DIR_RD,
      ST_DIR_WB,
      ST_TBL_RD,
      ST_TBL_WB,
      ST_RESP
   } walk_st_t;
endpackage

// File: rtl/pgw_entry_addr.sv
module pgw_entry_addr #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned IDX_W       = 10,
   parameter int unsigned OFF_W       = 12,
   parameter int unsigned ENTRY_BYTES = 4
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   localparam int unsigned SHIFT = $clog2(ENTRY_BYTES);
   localparam logic [ADDR_W-1:0] FRAME_MASK = ~((ADDR_W'(1) << OFF_W) - ADDR_W'(1));

   if ((1 << SHIFT) != ENTRY_BYTES) begin : g_bad_size
      $error("entry size must be a power of two");
   end
   if (IDX_W + SHIFT > OFF_W) begin : g_bad_fit
      $error("a table must fit inside one frame");
   end

   logic [ADDR_W-1:0] slot;

   if (SHIFT == 0) begin : g_byte_entries
      assign slot = ADDR_W'(idx);
   end else begin : g_wide_entries
      assign slot = ADDR_W'({idx, {SHIFT{1'b0}}});
   end

   assign addr = (base & FRAME_MASK) | slot;
endmodule

// File: rtl/pgw_perm.sv
module pgw_perm
   import pgw_pkg::*;
#(
   parameter int unsigned ENTRY_W   = 32,
   parameter bit          IS_DIR    = 1'b1,
   parameter bit          AD_UPDATE = 1'b1
) (
   input  logic [ENTRY_W-1:0] entry,
   input  logic               is_write,
   input  logic               is_user,
   output logic               fault,
   output logic               prot,
   output logic               need_wb,
   output logic [ENTRY_W-1:0] wb_data
);
   if (ENTRY_W <= BIT_BIGPAGE) begin : g_bad_width
      $error("entry too narrow for flag bits");
   end

   logic present, user_ok, write_ok, big_bad;
   logic [ENTRY_W-1:0] set_bits;

   assign present  = entry[BIT_PRESENT];
   assign user_ok  = !is_user || entry[BIT_USER];
   assign write_ok = !(is_user && is_write) || entry[BIT_WRITE];

   if (IS_DIR) begin : g_dir
      assign big_bad  = entry[BIT_BIGPAGE];
      assign set_bits = ENTRY_W'(1) << BIT_ACCESS;
   end else begin : g_tbl
      assign big_bad  = 1'b0;
      assign set_bits = (ENTRY_W'(1) << BIT_ACCESS)
                      | (is_write ? (ENTRY_W'(1) << BIT_DIRTY) : '0);
   end

   assign fault = !present || !user_ok || !write_ok || big_bad;
   assign prot  = present;

   if (AD_UPDATE) begin : g_ad_on
      assign need_wb = |(set_bits & ~entry);
      assign wb_data = entry | set_bits;
   end else begin : g_ad_off
      assign need_wb = 1'b0;
      assign wb_data = entry;
   end
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
   import pgw_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned IDX_W       = 10,
   parameter int unsigned OFF_W       = 12,
   parameter int unsigned ENTRY_BYTES = 4,
   parameter int unsigned VEC_W       = 8,
   parameter int unsigned PF_VECTOR   = 14,
   parameter bit          AD_UPDATE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              paging_en,
   input  logic [31:0]       dir_base,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [31:0]       req_lin,
   input  logic              req_write,
   input  logic              req_user,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [31:0]       rsp_phys,
   output logic              rsp_fault,
   output logic [2:0]        rsp_err,
   output logic [7:0]        rsp_vector,
   output logic [31:0]       fault_addr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [31:0]       mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata
);
   localparam int unsigned DIR_LO = OFF_W + IDX_W;

   if (ADDR_W != 32) begin : g_bad_addr
      $error("port widths are fixed at 32 bits");
   end
   if (ADDR_W != 2 * IDX_W + OFF_W) begin : g_bad_split
      $error("index and offset widths must cover the address");
   end
   if (VEC_W != 8 || PF_VECTOR >= (1 << VEC_W)) begin : g_bad_vec
      $error("fault vector does not fit");
   end

   walk_st_t          st_q;
   logic [ADDR_W-1:0] lin_q, base_q, dent_q, wb_q, phys_q, faddr_q;
   logic              wr_q, usr_q, fault_q;
   logic [2:0]        err_q;

   logic [ADDR_W-1:0] dir_addr, tbl_addr;
   logic              d_fault, d_prot, d_need, t_fault, t_prot, t_need;
   logic [ADDR_W-1:0] d_wb, t_wb;

   pgw_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
                    .ENTRY_BYTES(ENTRY_BYTES)) u_dir_addr (
      .base (base_q),
      .idx  (lin_q[ADDR_W-1:DIR_LO]),
      .addr (dir_addr)
   );

   pgw_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
                    .ENTRY_BYTES(ENTRY_BYTES)) u_tbl_addr (
      .base (dent_q),
      .idx  (lin_q[DIR_LO-1:OFF_W]),
      .addr (tbl_addr)
   );

   pgw_perm #(.ENTRY_W(ADDR_W), .IS_DIR(1'b1), .AD_UPDATE(AD_UPDATE)) u_dir_perm (
      .entry    (mem_rdata),
      .is_write (wr_q),
      .is_user  (usr_q),
      .fault    (d_fault),
      .prot     (d_prot),
      .need_wb  (d_need),
      .wb_data  (d_wb)
   );

   pgw_perm #(.ENTRY_W(ADDR_W), .IS_DIR(1'b0), .AD_UPDATE(AD_UPDATE)) u_tbl_perm (
      .entry    (mem_rdata),
      .is_write (wr_q),
      .is_user  (usr_q),
      .fault    (t_fault),
      .prot     (t_prot),
      .need_wb  (t_need),
      .wb_data  (t_wb)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         lin_q   <= '0;
         base_q  <= '0;
         dent_q  <= '0;
         wb_q    <= '0;
         phys_q  <= '0;
         faddr_q <= '0;
         wr_q    <= 1'b0;
         usr_q   <= 1'b0;
         fault_q <= 1'b0;
         err_q   <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  lin_q   <= req_lin;
                  wr_q    <= req_write;
                  usr_q   <= req_user;
                  base_q  <= dir_base;
                  fault_q <= 1'b0;
                  err_q   <= '0;
                  if (paging_en) begin
                     st_q <= ST_DIR_RD;
                  end else begin
                     phys_q <= req_lin;
                     st_q   <= ST_RESP;
                  end
               end
            end
            ST_DIR_RD: begin
               if (mem_ack) begin
                  if (d_fault) begin
                     fault_q            <= 1'b1;
                     faddr_q            <= lin_q;
                     err_q[ERR_PROT]    <= d_prot;
                     err_q[ERR_WRITE]   <= wr_q;
                     err_q[ERR_USER]    <= usr_q;
                     st_q               <= ST_RESP;
                  end else begin
                     dent_q <= mem_rdata;
                     wb_q   <= d_wb;
                     st_q   <= d_need ? ST_DIR_WB : ST_TBL_RD;
                  end
               end
            end
            ST_DIR_WB: begin
               if (mem_ack) st_q <= ST_TBL_RD;
            end
            ST_TBL_RD: begin
               if (mem_ack) begin
                  if (t_fault) begin
                     fault_q            <= 1'b1;
                     faddr_q            <= lin_q;
                     err_q[ERR_PROT]    <= t_prot;
                     err_q[ERR_WRITE]   <= wr_q;
                     err_q[ERR_USER]    <= usr_q;
                     st_q               <= ST_RESP;
                  end else begin
                     phys_q <= {mem_rdata[ADDR_W-1:OFF_W], lin_q[OFF_W-1:0]};
                     wb_q   <= t_wb;
                     st_q   <= t_need ? ST_TBL_WB : ST_RESP;
                  end
               end
            end
            ST_TBL_WB: begin
               if (mem_ack) st_q <= ST_RESP;
            end
            ST_RESP: begin
               if (rsp_ready) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req  = 1'b0;
      mem_we   = 1'b0;
      mem_addr = dir_addr;
      unique case (st_q)
         ST_DIR_RD: mem_req = 1'b1;
         ST_DIR_WB: begin mem_req = 1'b1; mem_we = 1'b1; end
         ST_TBL_RD: begin mem_req = 1'b1; mem_addr = tbl_addr; end
         ST_TBL_WB: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = tbl_addr; end
         default: ;
      endcase
   end

   assign mem_wdata  = wb_q;
   assign req_ready  = (st_q == ST_IDLE);
   assign rsp_valid  = (st_q == ST_RESP);
   assign rsp_phys   = phys_q;
   assign rsp_fault  = fault_q;
   assign rsp_err    = err_q;
   assign rsp_vector = fault_q ? VEC_W'(PF_VECTOR) : '0;
   assign fault_addr = faddr_q;
endmodule

// File: rtl/pgw_walker_chk.sv
module pgw_walker_chk #(
   parameter int unsigned OFF_W     = 12,
   parameter int unsigned PF_VECTOR = 14
) (
   input logic        clk,
   input logic        rst_n,
   input logic        paging_en,
   input logic        req_valid,
   input logic        req_ready,
   input logic [31:0] req_lin,
   input logic        rsp_valid,
   input logic        rsp_ready,
   input logic [31:0] rsp_phys,
   input logic        rsp_fault,
   input logic [2:0]  rsp_err,
   input logic [7:0]  rsp_vector,
   input logic [31:0] fault_addr,
   input logic        mem_req,
   input logic        mem_we,
   input logic [31:0] mem_addr,
   input logic [31:0] mem_wdata,
   input logic        mem_ack
);
   logic [31:0] lin_sh;

   always_ff @(posedge clk) begin
      if (!rst_n)                       lin_sh <= '0;
      else if (req_valid && req_ready)  lin_sh <= req_lin;
   end

   a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !paging_en) |=>
         (rsp_valid && !rsp_fault && rsp_phys == $past(req_lin) && !mem_req));

   a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=>
         (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=>
         (rsp_valid && $stable(rsp_phys) && $stable(rsp_fault) && $stable(rsp_err)));

   a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!rsp_valid && !mem_req));

   a_r7_fault_report: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_vector == 8'(PF_VECTOR) && fault_addr == lin_sh));

   a_r2_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault) |-> (rsp_phys[OFF_W-1:0] == lin_sh[OFF_W-1:0]));

   a_r8_wb_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_wdata[0] && mem_wdata[5]));
endmodule

bind pgw_walker pgw_walker_chk #(.OFF_W(OFF_W), .PF_VECTOR(PF_VECTOR)) u_chk (
   .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .req_valid(req_valid),
   .req_ready(req_ready), .req_lin(req_lin), .rsp_valid(rsp_valid),
   .rsp_ready(rsp_ready), .rsp_phys(rsp_phys), .rsp_fault(rsp_fault),
   .rsp_err(rsp_err), .rsp_vector(rsp_vector), .fault_addr(fault_addr),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/pgw_walker_tb.sv
`timescale 1ns/1ps
module pgw_walker_tb_top;
   typedef struct {
      logic [31:0] lin;
      logic        flt;
      logic [31:0] phys;
      logic [2:0]  err;
      string       tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic paging_en = 1'b0;
   logic [31:0] dir_base = 32'h0001_0000;
   logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
   logic [31:0] req_lin = '0;
   logic rsp_ready = 1'b0;
   logic mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic req_ready, rsp_valid, rsp_fault, mem_req, mem_we;
   logic [31:0] rsp_phys, fault_addr, mem_addr, mem_wdata;
   logic [2:0] rsp_err;
   logic [7:0] rsp_vector;

   int checks = 0;
   int errors = 0;
   int wr_total = 0;
   int cyc = 0;
   int wait_c = 0;
   logic [31:0] mem [int unsigned];
   logic [31:0] last_fault = '0;
   exp_t q[$];

   always #4 clk = ~clk;

   pgw_walker dut_i (
      .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .dir_base(dir_base),
      .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
      .req_write(req_write), .req_user(req_user), .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready), .rsp_phys(rsp_phys), .rsp_fault(rsp_fault),
      .rsp_err(rsp_err), .rsp_vector(rsp_vector), .fault_addr(fault_addr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory model: variable latency, one ack per access
   always @(posedge clk) begin
      cyc <= cyc + 1;
      rsp_ready <= (cyc % 3) != 0;
      if (mem_ack) begin
         mem_ack <= 1'b0;
      end else if (mem_req) begin
         if (wait_c >= (cyc % 3)) begin
            wait_c    <= 0;
            mem_ack   <= 1'b1;
            mem_rdata <= rd(mem_addr);
            if (mem_we) begin
               mem[mem_addr] = mem_wdata;
               wr_total <= wr_total + 1;
            end
         end else begin
            wait_c <= wait_c + 1;
         end
      end
   end

   // monitor: compares responses against the scoreboard
   always @(negedge clk) begin
      if (rst_n && rsp_valid && rsp_ready) begin
         if (q.size() == 0) begin
            chk(1'b0, "R10 unexpected response", {31'h0, rsp_fault}, 32'h0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(rsp_fault == e.flt, {e.tag, " fault"}, {31'h0, rsp_fault}, {31'h0, e.flt});
            if (e.flt) begin
               last_fault = e.lin;
               chk(rsp_err == e.err, {e.tag, " R7 error code"}, {29'h0, rsp_err}, {29'h0, e.err});
               chk(rsp_vector == 8'd14, {e.tag, " R7 vector"}, {24'h0, rsp_vector}, 32'd14);
            end else begin
               chk(rsp_phys == e.phys, {e.tag, " R2 phys"}, rsp_phys, e.phys);
            end
            chk(fault_addr == last_fault, {e.tag, " R7 fault_addr"}, fault_addr, last_fault);
            chk(!req_ready, "R10 busy while response pending", {31'h0, req_ready}, 32'h0);
         end
      end
   end

   task automatic walk(input logic [31:0] lin, input bit wr, input bit usr,
                       input bit pg, input string tag);
      exp_t e;
      int nw = 0;
      int wc0;
      bit chk_d = 0, chk_t = 0;
      logic [31:0] da = '0, de, ta = '0, te, dexp = '0, texp = '0, tset;
      e.lin = lin; e.flt = 1'b0; e.phys = lin; e.err = '0; e.tag = tag;
      if (pg) begin
         da = {dir_base[31:12], 12'h0} + {20'h0, lin[31:22], 2'b00};
         de = rd(da);
         if (!de[0] || de[7] || (usr && !de[2]) || (usr && wr && !de[1])) begin
            e.flt = 1'b1; e.err = {usr, wr, de[0]};
         end else begin
            if (!de[5]) nw++;
            dexp = de | 32'h20; chk_d = 1;
            ta = {de[31:12], 12'h0} + {20'h0, lin[21:12], 2'b00};
            te = rd(ta);
            if (!te[0] || (usr && !te[2]) || (usr && wr && !te[1])) begin
               e.flt = 1'b1; e.err = {usr, wr, te[0]};
               texp = te; chk_t = 1;
            end else begin
               tset = 32'h20 | (wr ? 32'h40 : 32'h0);
               if ((te & tset) != tset) nw++;
               texp = te | tset; chk_t = 1;
               e.phys = {te[31:12], lin[11:0]};
            end
         end
      end
      q.push_back(e);
      wc0 = wr_total;
      @(negedge clk);
      req_valid = 1'b1; req_lin = lin; req_write = wr; req_user = usr; paging_en = pg;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(wr_total - wc0 == nw, {tag, " R8 write-back count"}, wr_total - wc0, nw);
      if (chk_d) chk(rd(da) == dexp, {tag, " R8 R11 directory entry"}, rd(da), dexp);
      if (chk_t) chk(rd(ta) == texp, {tag, " R9 table entry"}, rd(ta), texp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      mem[32'h0001_0004] = 32'h0002_0007;   // dir 1: present, writable, user
      mem[32'h0001_000C] = 32'h0030_0087;   // dir 3: large page
      mem[32'h0001_0010] = 32'h0002_1003;   // dir 4: supervisor only
      mem[32'h0002_0008] = 32'h0ABC_D007;   // pte 2: full access
      mem[32'h0002_000C] = 32'h0BBB_B003;   // pte 3: supervisor only
      mem[32'h0002_0010] = 32'h0CCC_C005;   // pte 4: read-only user
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R10 reset ready", {31'h0, req_ready}, 32'h1);
      chk(rsp_valid == 1'b0, "R10 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
      chk(mem_req == 1'b0, "R11 reset mem_req", {31'h0, mem_req}, 32'h0);
      chk(fault_addr == 32'h0, "R7 reset fault_addr", fault_addr, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      walk(32'h1234_5678, 1, 1, 0, "R1 bypass");
      walk(32'h0040_2123, 0, 0, 1, "R2 R8 first read");
      walk(32'h0040_2FFC, 1, 1, 1, "R9 user write sets dirty");
      walk(32'h0040_2004, 0, 1, 1, "R8 no write when flags set");
      walk(32'h0080_0010, 1, 1, 1, "R3 dir not present");
      walk(32'h0040_5000, 0, 0, 1, "R3 table not present");
      walk(32'h0040_3010, 0, 1, 1, "R4 user on supervisor page");
      walk(32'h0040_3010, 0, 0, 1, "R4 supervisor allowed");
      walk(32'h0040_4020, 1, 1, 1, "R5 user write read-only");
      walk(32'h0040_4020, 1, 0, 1, "R5 supervisor write allowed");
      walk(32'h0040_4030, 0, 1, 1, "R9 read keeps dirty");
      walk(32'h00C0_0000, 0, 0, 1, "R6 large page");
      walk(32'h0100_0000, 0, 1, 1, "R4 dir supervisor only");
      walk(32'h0100_0000, 0, 0, 1, "R3 supervisor via dir4 empty table");
      walk(32'hFFFF_F000, 0, 0, 0, "R1 bypass high");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule